// File: doc/BRIEF.md
# Timestamp Capture and Compare Unit

This unit sits beside a free-running precision time counter and takes in its seconds and nanoseconds value every clock. When the frame path raises a transmit or receive event strobe, the unit stores that time in a capture slot kept for that direction. Software later reads the slot through a small word-wide register port. Each capture sets a sticky status flag, and an interrupt line is raised for every flag whose enable bit is set.

The unit also holds a programmed target time. A registered match output is high for as long as the seconds field and the upper nanoseconds bits equal the target. The low nanosecond bits play no part in this match, so it lasts for many clocks, and other timer logic can use the match output to trigger. The compare status flag is set only on the first cycle of a match and only while its enable bit is set.

Top module: `tsu_capture_compare`

## Requirements
- R1: When `tx_evt` is high at a clock edge, the transmit slot holds the sampled `time_sec` and `time_ns` after that edge. The slot reads at address 5 (nanoseconds, zero-extended), address 6 (seconds bits 31:0) and address 7 (seconds bits above 31).
- R2: When `rx_evt` is high at a clock edge, the receive slot holds the sampled time after that edge. The slot reads at addresses 8, 9 and 10 with the same layout as R1. A receive capture leaves the transmit slot unchanged, and a transmit capture leaves the receive slot unchanged.
- R3: Each transmit capture sets status bit 0 and each receive capture sets status bit 1. The status register is at address 0. Both flags stay set until software clears them.
- R4: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged. When a clear and a capture hit the same flag in the same cycle, the flag stays set.
- R5: `cmp_match` is high in the cycle after the one in which `time_sec` equals the target seconds and `time_ns[29:8]` equals the stored target bits. Nanosecond bits 7:0 have no effect on the match.
- R6: Status bit 29 is set on the first cycle in which equality starts, and only if enable bit 29 is set in that cycle. Clearing bit 29 while equality continues does not set it again. It is set again only after equality has ended and then started again.
- R7: `irq` is high exactly when some status bit and the matching enable bit (address 1, bits 0, 1 and 29) are both set.
- R8: A read of a capture word in the same cycle as a capture into that slot returns the previous value. The new value is returned from the next cycle.
- R9: While reset is asserted, every register reads 0 and `cmp_match` and `irq` are low.
- R10: The target nanoseconds word is at address 2 and keeps only bits 29:8, reading back with bits 7:0 as zero. The target seconds are at address 3 (bits 31:0) and address 4 (bits above 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_sec | input | SEC_W | Current seconds value from the time counter |
| time_ns | input | NS_W | Current nanoseconds value from the time counter |
| tx_evt | input | 1 | Transmit event-frame strobe |
| rx_evt | input | 1 | Receive event-frame strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| cmp_match | output | 1 | Registered compare-match level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default widths: 48 seconds bits, 30 nanoseconds bits and a 22-bit compare field. With 48 seconds bits, the seconds words above bit 31 exist for the target and for both capture slots. A table of compare vectors changes the top seconds bit, the lowest seconds bit, nanoseconds bit 8, nanoseconds bit 29 and the masked low byte, so each edge of the compare field is tested. The directed tests cover a clear colliding with a capture, a read colliding with a capture, and a match that continues after its flag is cleared.

// File: rtl/tsu_cc_pkg.sv
package tsu_cc_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_AW  = 4;
    localparam int NUM_CAP = 2;

    // capture slot indices
    localparam int CAP_TX = 0;
    localparam int CAP_RX = 1;

    // status / enable bit positions
    localparam int BIT_TX  = 0;
    localparam int BIT_RX  = 1;
    localparam int BIT_CMP = 29;

    typedef enum logic [REG_AW-1:0] {
        A_STATUS     = 4'd0,
        A_ENABLE     = 4'd1,
        A_CMP_NS     = 4'd2,
        A_CMP_SEC_LO = 4'd3,
        A_CMP_SEC_HI = 4'd4,
        A_TX_NS      = 4'd5,
        A_TX_SEC_LO  = 4'd6,
        A_TX_SEC_HI  = 4'd7,
        A_RX_NS      = 4'd8,
        A_RX_SEC_LO  = 4'd9,
        A_RX_SEC_HI  = 4'd10
    } reg_addr_e;

endpackage

// File: rtl/tsu_cap_slot.sv
module tsu_cap_slot #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [SEC_W-1:0] time_sec,
    input  logic [NS_W-1:0]  time_ns,
    output logic [SEC_W-1:0] cap_sec,
    output logic [NS_W-1:0]  cap_ns
);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (strobe) begin
            slot_d.sec = time_sec;
            slot_d.ns  = time_ns;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign cap_sec = slot_q.sec;
    assign cap_ns  = slot_q.ns;

endmodule

// File: rtl/tsu_cmp_unit.sv
module tsu_cmp_unit #(
    parameter int SEC_W    = 48,
    parameter int CMP_NS_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEC_W-1:0]    time_sec,
    input  logic [CMP_NS_W-1:0] time_ns_hi,
    input  logic [SEC_W-1:0]    tgt_sec,
    input  logic [CMP_NS_W-1:0] tgt_ns_hi,
    output logic                match,
    output logic                match_rise
);

    typedef struct packed {
        logic match;
    } cmp_t;

    cmp_t cmp_d, cmp_q;
    logic equal_now;

    always_comb begin
        equal_now   = (time_sec == tgt_sec) && (time_ns_hi == tgt_ns_hi);
        cmp_d       = cmp_q;
        cmp_d.match = equal_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    // first cycle of equality: current equal, registered level still low
    assign match      = cmp_q.match;
    assign match_rise = equal_now & ~cmp_q.match;

endmodule

// File: rtl/tsu_cc_regs.sv
module tsu_cc_regs
    import tsu_cc_pkg::*;
#(
    parameter int SEC_W    = 48,
    parameter int NS_W     = 30,
    parameter int CMP_NS_W = 22
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [REG_AW-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic [NUM_CAP-1:0]              cap_set,
    input  logic                            cmp_rise,
    input  logic [NUM_CAP-1:0][SEC_W-1:0]   cap_sec,
    input  logic [NUM_CAP-1:0][NS_W-1:0]    cap_ns,
    output logic [SEC_W-1:0]                tgt_sec,
    output logic [CMP_NS_W-1:0]             tgt_ns_hi,
    output logic [DATA_W-1:0]               status,
    output logic [DATA_W-1:0]               enable,
    output logic [DATA_W-1:0]               rdata,
    output logic                            irq
);

    localparam int NS_LSB   = NS_W - CMP_NS_W;
    localparam int SEC_HI_W = SEC_W - DATA_W;
    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << BIT_TX) | (DATA_W'(1) << BIT_RX) | (DATA_W'(1) << BIT_CMP);

    typedef struct packed {
        logic [DATA_W-1:0]   status;
        logic [DATA_W-1:0]   enable;
        logic [SEC_W-1:0]    tgt_sec;
        logic [CMP_NS_W-1:0] tgt_ns;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [DATA_W-1:0] set_vec;

    always_comb begin
        regs_d = regs_q;

        set_vec          = '0;
        set_vec[BIT_TX]  = cap_set[CAP_TX];
        set_vec[BIT_RX]  = cap_set[CAP_RX];
        set_vec[BIT_CMP] = cmp_rise & regs_q.enable[BIT_CMP];

        if (reg_wr) begin
            case (reg_addr)
                A_STATUS:     regs_d.status = regs_q.status & ~reg_wdata;
                A_ENABLE:     regs_d.enable = reg_wdata & FLAG_MASK;
                A_CMP_NS:     regs_d.tgt_ns = reg_wdata[NS_W-1:NS_LSB];
                A_CMP_SEC_LO: regs_d.tgt_sec[DATA_W-1:0] = reg_wdata;
                A_CMP_SEC_HI: regs_d.tgt_sec[SEC_W-1:DATA_W] = reg_wdata[SEC_HI_W-1:0];
                default:      ;
            endcase
        end

        // hardware set wins over a same-cycle clear
        regs_d.status = (regs_d.status | set_vec) & FLAG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_STATUS:     rdata = regs_q.status;
            A_ENABLE:     rdata = regs_q.enable;
            A_CMP_NS:     rdata = DATA_W'(regs_q.tgt_ns) << NS_LSB;
            A_CMP_SEC_LO: rdata = regs_q.tgt_sec[DATA_W-1:0];
            A_CMP_SEC_HI: rdata = DATA_W'(regs_q.tgt_sec[SEC_W-1:DATA_W]);
            A_TX_NS:      rdata = DATA_W'(cap_ns[CAP_TX]);
            A_TX_SEC_LO:  rdata = cap_sec[CAP_TX][DATA_W-1:0];
            A_TX_SEC_HI:  rdata = DATA_W'(cap_sec[CAP_TX][SEC_W-1:DATA_W]);
            A_RX_NS:      rdata = DATA_W'(cap_ns[CAP_RX]);
            A_RX_SEC_LO:  rdata = cap_sec[CAP_RX][DATA_W-1:0];
            A_RX_SEC_HI:  rdata = DATA_W'(cap_sec[CAP_RX][SEC_W-1:DATA_W]);
            default:      rdata = '0;
        endcase
    end

    assign tgt_sec   = regs_q.tgt_sec;
    assign tgt_ns_hi = regs_q.tgt_ns;
    assign status    = regs_q.status;
    assign enable    = regs_q.enable;
    assign irq       = |(regs_q.status & regs_q.enable);

endmodule

// File: rtl/tsu_capture_compare.sv
module tsu_capture_compare
    import tsu_cc_pkg::*;
#(
    parameter int SEC_W    = 48,
    parameter int NS_W     = 30,
    parameter int CMP_NS_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  time_sec,
    input  logic [NS_W-1:0]   time_ns,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmp_match,
    output logic              irq
);

    localparam int NS_LSB = NS_W - CMP_NS_W;

    logic [NUM_CAP-1:0]            evt_vec;
    logic [NUM_CAP-1:0][SEC_W-1:0] cap_sec_w;
    logic [NUM_CAP-1:0][NS_W-1:0]  cap_ns_w;
    logic [SEC_W-1:0]              tgt_sec_w;
    logic [CMP_NS_W-1:0]           tgt_ns_w;
    logic [DATA_W-1:0]             status_w;
    logic [DATA_W-1:0]             enable_w;
    logic                          match_rise_w;

    always_comb begin
        evt_vec         = '0;
        evt_vec[CAP_TX] = tx_evt;
        evt_vec[CAP_RX] = rx_evt;
    end

    for (genvar g = 0; g < NUM_CAP; g++) begin : g_slot
        tsu_cap_slot #(
            .SEC_W (SEC_W),
            .NS_W  (NS_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (evt_vec[g]),
            .time_sec (time_sec),
            .time_ns  (time_ns),
            .cap_sec  (cap_sec_w[g]),
            .cap_ns   (cap_ns_w[g])
        );
    end

    tsu_cmp_unit #(
        .SEC_W    (SEC_W),
        .CMP_NS_W (CMP_NS_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_sec   (time_sec),
        .time_ns_hi (time_ns[NS_W-1:NS_LSB]),
        .tgt_sec    (tgt_sec_w),
        .tgt_ns_hi  (tgt_ns_w),
        .match      (cmp_match),
        .match_rise (match_rise_w)
    );

    tsu_cc_regs #(
        .SEC_W    (SEC_W),
        .NS_W     (NS_W),
        .CMP_NS_W (CMP_NS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cap_set   (evt_vec),
        .cmp_rise  (match_rise_w),
        .cap_sec   (cap_sec_w),
        .cap_ns    (cap_ns_w),
        .tgt_sec   (tgt_sec_w),
        .tgt_ns_hi (tgt_ns_w),
        .status    (status_w),
        .enable    (enable_w),
        .rdata     (reg_rdata),
        .irq       (irq)
    );

endmodule

// File: rtl/tsu_capture_compare_chk.sv
module tsu_capture_compare_chk #(
    parameter int SEC_W    = 48,
    parameter int NS_W     = 30,
    parameter int CMP_NS_W = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SEC_W-1:0]        time_sec,
    input logic [NS_W-1:0]         time_ns,
    input logic                    tx_evt,
    input logic                    rx_evt,
    input logic                    reg_wr,
    input logic [3:0]              reg_addr,
    input logic                    wdata_b0,
    input logic                    cmp_match,
    input logic                    irq,
    input logic [1:0][SEC_W-1:0]   cap_sec,
    input logic [1:0][NS_W-1:0]    cap_ns,
    input logic [SEC_W-1:0]        tgt_sec,
    input logic [CMP_NS_W-1:0]     tgt_ns,
    input logic [31:0]             status,
    input logic [31:0]             enable
);

    localparam int NS_LSB = NS_W - CMP_NS_W;

    logic eq_ref;
    assign eq_ref = (time_sec == tgt_sec) && (time_ns[NS_W-1:NS_LSB] == tgt_ns);

    assert_tx_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> (cap_sec[0] == $past(time_sec)) && (cap_ns[0] == $past(time_ns)));

    assert_rx_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> (cap_sec[1] == $past(time_sec)) && (cap_ns[1] == $past(time_ns)));

    assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_evt |=> $stable(cap_sec[0]) && $stable(cap_ns[0]));

    assert_tx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> status[0]);

    assert_rx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> status[1]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd0 && wdata_b0 && !tx_evt) |=> !status[0]);

    assert_match_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (cmp_match == $past(eq_ref)));

    assert_cmp_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_ref && !cmp_match && enable[29]) |=> status[29]);

    assert_cmp_flag_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable[29] && !status[29]) |=> !status[29]);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable) == 32'd0) |-> !irq);

endmodule

bind tsu_capture_compare tsu_capture_compare_chk #(
    .SEC_W    (SEC_W),
    .NS_W     (NS_W),
    .CMP_NS_W (CMP_NS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_sec  (time_sec),
    .time_ns   (time_ns),
    .tx_evt    (tx_evt),
    .rx_evt    (rx_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wdata_b0  (reg_wdata[0]),
    .cmp_match (cmp_match),
    .irq       (irq),
    .cap_sec   (cap_sec_w),
    .cap_ns    (cap_ns_w),
    .tgt_sec   (tgt_sec_w),
    .tgt_ns    (tgt_ns_w),
    .status    (status_w),
    .enable    (enable_w)
);

// File: tb/tsu_capture_compare_tb.sv
module tsu_capture_compare_tb;

    localparam int SEC_W = 48;
    localparam int NS_W  = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SEC_W-1:0]  time_sec = 48'd1;
    logic [NS_W-1:0]   time_ns = 30'd0;
    logic              tx_evt = 1'b0;
    logic              rx_evt = 1'b0;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = 4'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       reg_rdata;
    logic              cmp_match;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsu_capture_compare u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_sec  (time_sec),
        .time_ns   (time_ns),
        .tx_evt    (tx_evt),
        .rx_evt    (rx_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_match (cmp_match),
        .irq       (irq)
    );

    // {time_sec, time_ns, expected cmp_match}; target is sec 0x00A5_BEEF_1234, ns[29:8] of 0x1ABCDE00
    localparam logic [78:0] CMP_VEC [6] = '{
        {48'h00A5_BEEF_1234, 30'h1ABC_DE00, 1'b1},
        {48'h00A5_BEEF_1234, 30'h1ABC_DEFF, 1'b1},
        {48'h00A5_BEEF_1234, 30'h1ABC_DF00, 1'b0},
        {48'h00A5_BEEF_1235, 30'h1ABC_DE00, 1'b0},
        {48'h80A5_BEEF_1234, 30'h1ABC_DE00, 1'b0},
        {48'h00A5_BEEF_1234, 30'h3ABC_DE00, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;

        // R9: reset state
        repeat (3) @(negedge clk);
        rd(4'd0, v);  chk("R9 status in reset", v, 0);
        rd(4'd5, v);  chk("R9 tx ns in reset", v, 0);
        chk("R9 cmp_match in reset", cmp_match, 0);
        chk("R9 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: target programming and readback
        wr(4'd3, 32'hBEEF_1234);
        wr(4'd4, 32'h0000_00A5);
        wr(4'd2, 32'h1ABC_DE55);
        rd(4'd2, v);  chk("R10 target ns readback", v, 32'h1ABC_DE00);
        rd(4'd4, v);  chk("R10 target sec hi readback", v, 32'h0000_00A5);

        // R5: compare vector table, enable bit 29 clear
        for (int i = 0; i < 6; i++) begin
            time_sec = CMP_VEC[i][78:31];
            time_ns  = CMP_VEC[i][30:1];
            @(negedge clk);
            chk("R5 compare vector", cmp_match, CMP_VEC[i][0]);
        end
        rd(4'd0, v);  chk("R6 no flag while disabled", v, 0);

        // R1 / R3: transmit capture
        time_sec = 48'h1111_2222_3333;
        time_ns  = 30'h0123_4567;
        tx_evt   = 1'b1;
        @(negedge clk);
        tx_evt   = 1'b0;
        time_sec = 48'd9;
        rd(4'd5, v);  chk("R1 tx ns", v, 32'h0123_4567);
        rd(4'd6, v);  chk("R1 tx sec lo", v, 32'h2222_3333);
        rd(4'd7, v);  chk("R1 tx sec hi", v, 32'h0000_1111);
        rd(4'd8, v);  chk("R2 rx untouched by tx", v, 0);
        rd(4'd0, v);  chk("R3 tx flag", v, 32'h1);

        // R2 / R3: receive capture
        time_sec = 48'h4444_5555_6666;
        time_ns  = 30'h2345_6789;
        rx_evt   = 1'b1;
        @(negedge clk);
        rx_evt   = 1'b0;
        time_sec = 48'd9;
        rd(4'd8, v);  chk("R2 rx ns", v, 32'h2345_6789);
        rd(4'd9, v);  chk("R2 rx sec lo", v, 32'h5555_6666);
        rd(4'd10, v); chk("R2 rx sec hi", v, 32'h0000_4444);
        rd(4'd5, v);  chk("R2 tx untouched by rx", v, 32'h0123_4567);
        rd(4'd0, v);  chk("R3 both flags sticky", v, 32'h3);

        // R7: interrupt gating
        chk("R7 irq with no enables", irq, 0);
        wr(4'd1, 32'h1);
        chk("R7 irq with tx enabled", irq, 1);
        wr(4'd1, 32'h0);
        chk("R7 irq after disable", irq, 0);

        // R4: write-one-to-clear
        wr(4'd0, 32'h1);
        rd(4'd0, v);  chk("R4 clear bit 0 only", v, 32'h2);
        wr(4'd0, 32'h0);
        rd(4'd0, v);  chk("R4 zero write no effect", v, 32'h2);
        time_sec  = 48'd7;
        time_ns   = 30'h42;
        tx_evt    = 1'b1;
        wr(4'd0, 32'h1);
        tx_evt    = 1'b0;
        rd(4'd0, v);  chk("R4 set wins over clear", v, 32'h3);

        // R8: read colliding with capture
        time_ns  = 30'h99;
        tx_evt   = 1'b1;
        rd(4'd5, v);  chk("R8 same-cycle read old", v, 32'h42);
        @(negedge clk);
        tx_evt   = 1'b0;
        rd(4'd5, v);  chk("R8 next read new", v, 32'h99);

        // R6: compare flag on first cycle of equality
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'h2000_0000);
        time_sec = 48'h00A5_BEEF_1234;
        time_ns  = 30'h1ABC_DE10;
        @(negedge clk);
        rd(4'd0, v);  chk("R6 flag on equality start", v, 32'h2000_0000);
        chk("R7 irq from compare", irq, 1);
        wr(4'd0, 32'h2000_0000);
        repeat (3) @(negedge clk);
        rd(4'd0, v);  chk("R6 no re-set while equal", v, 0);
        chk("R5 match persists", cmp_match, 1);
        time_ns  = 30'h0000_0010;
        @(negedge clk);
        time_ns  = 30'h1ABC_DEF0;
        @(negedge clk);
        rd(4'd0, v);  chk("R6 flag on new equality", v, 32'h2000_0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule